// File: doc/BRIEF.md
# Multi-IO Flash Lane Serializer

This block is the bit-level datapath of a serial flash controller. A phase controller tells it which part of a transaction is on the wire (command, address, turnaround, write data or read data) and which interface code the transaction uses. The block then moves bytes over one, two or four bidirectional IO lines. The lane count is picked separately for each phase from that one code, so a single transaction can send its command on one line, its address on two and its data on four.

On transmit, the block takes a byte from `tx_byte` on the first clock of each byte and shifts it out most significant group first. On receive, it assembles groups sampled from the IO lines into `rx_byte`. Pad drive values and output enables are registered. During turnaround and read data, every enable is dropped so the flash can take the bus. `byte_done` marks the clock whose edge handles the last group of a byte, so the controller can count bytes and change phase at that same edge.

Top module: `flane_serializer`

## Requirements
- R1: While reset is held and after it is released, `io_out`, `io_oe`, `byte_done`, `rx_valid` and `rx_byte` are all zero.
- R2: Lane count per phase follows the interface code. The command phase always uses 1 lane. The address phase uses 2 lanes for code 2, 4 lanes for code 4 and 1 lane otherwise. Both data phases use 2 lanes for codes 1 and 2, 4 lanes for codes 3 and 4, and 1 lane for code 0. The phase encoding is 0 idle, 1 command, 2 address, 3 dummy, 4 write data, 5 read data; 6 and 7 act as idle.
- R3: Bytes go out most significant group first. Inside a group of k bits, the highest bit appears on lane k-1 and the lowest on lane 0, so single-lane output uses IO0. Unused lanes drive 0.
- R4: A byte occupies 8, 4 or 2 consecutive clocks on 1, 2 or 4 lanes. `byte_done` is high, combinationally, exactly during the last of those clocks.
- R5: `tx_byte` is captured only on the first clock of a byte; its value on the remaining clocks of that byte has no effect on `io_out`.
- R6: During a driving phase (command, address, write data), the edge registers `io_oe` with exactly the active lanes set (0001, 0011 or 1111) and `io_out` with the current group.
- R7: The edge after a dummy clock leaves all four `io_oe` bits at 0 and `io_out` at 0, and a dummy clock never raises `byte_done`.
- R8: In the read-data phase all enables are 0. Single-lane reads sample IO1; two-lane reads sample IO1:IO0; four-lane reads sample IO3:IO0, with the higher lane holding the more significant bit. On the edge that ends a byte, `rx_byte` takes the assembled byte and `rx_valid` pulses high for one cycle. `rx_byte` holds its value otherwise.
- R9: An idle clock zeroes `io_out` and `io_oe` and discards any partial byte, so the next active phase starts at a byte boundary.
- R10: Interface codes 5, 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one flash clock per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_code | input | 3 | Interface code selecting per-phase lane counts |
| phase | input | 3 | Current transaction phase |
| tx_byte | input | BYTE_W (8) | Byte to send, read on the first clock of a byte |
| byte_done | output | 1 | Current clock handles the last group of a byte |
| io_out | output | 4 | Registered drive values for IO3..IO0 |
| io_oe | output | 4 | Registered output enables for IO3..IO0 |
| io_in | input | 4 | Values sampled from IO3..IO0 |
| rx_byte | output | BYTE_W (8) | Last byte received |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` has just been updated |

## Verification
The bench runs full command/address/dummy/data sequences under all eight interface codes. This is aimed at a per-phase lane table that is wrong for the mixed codes 2 and 4: such a design sends the address on the data width or the command on more than one lane. The bench rebuilds every transmitted byte from the pads alone and keeps changing `tx_byte` in the middle of each byte. A reversed lane order, or a design that reloads the byte on every clock, produces a different rebuilt byte. Single-lane reads put the data bit on IO1 and noise on IO0, so a design that samples the wrong pin stores noise. Enables are watched through dummy clocks, where a missing turnaround leaves lanes driven. An aborted command byte followed by idle checks that the counter restarts; without that restart, `byte_done` falls in the middle of the next byte.

// File: rtl/flane_pkg.sv
package flane_pkg;

   localparam logic [2:0] PH_IDLE  = 3'd0;
   localparam logic [2:0] PH_CMD   = 3'd1;
   localparam logic [2:0] PH_ADDR  = 3'd2;
   localparam logic [2:0] PH_DUMMY = 3'd3;
   localparam logic [2:0] PH_WDATA = 3'd4;
   localparam logic [2:0] PH_RDATA = 3'd5;

   // log2 of the active lane count
   typedef enum logic [1:0] {
      LW1 = 2'd0,
      LW2 = 2'd1,
      LW4 = 2'd2
   } lw_e;

   function automatic lw_e pick_width(input logic [2:0] code, input logic [2:0] ph);
      lw_e r;
      r = LW1;
      case (ph)
         PH_ADDR: begin
            if (code == 3'd2)      r = LW2;
            else if (code == 3'd4) r = LW4;
         end
         PH_WDATA, PH_RDATA: begin
            case (code)
               3'd1, 3'd2: r = LW2;
               3'd3, 3'd4: r = LW4;
               default:    r = LW1;
            endcase
         end
         default: r = LW1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/flane_decode.sv
module flane_decode (
   input  logic            [2:0] if_code,
   input  logic            [2:0] phase,
   output flane_pkg::lw_e        lw,
   output logic                  drive,
   output logic                  sample,
   output logic            [3:0] lane_mask
);
   import flane_pkg::*;

   always_comb begin
      lw     = pick_width(if_code, phase);
      drive  = (phase == PH_CMD) || (phase == PH_ADDR) || (phase == PH_WDATA);
      sample = (phase == PH_RDATA);
      lane_mask = 4'b0000;
      if (drive) begin
         case (lw)
            LW4:     lane_mask = 4'b1111;
            LW2:     lane_mask = 4'b0011;
            default: lane_mask = 4'b0001;
         endcase
      end
   end

endmodule

// File: rtl/flane_counter.sv
module flane_counter #(
   parameter int BYTE_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           active,
   input  flane_pkg::lw_e lw,
   output logic           at_first,
   output logic           at_last
);
   import flane_pkg::*;

   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LIM1 = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] LIM2 = CNT_W'(BYTE_W / 2 - 1);
   localparam logic [CNT_W-1:0] LIM4 = CNT_W'(BYTE_W / 4 - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   always_comb begin
      case (lw)
         LW4:     lim = LIM4;
         LW2:     lim = LIM2;
         default: lim = LIM1;
      endcase
   end

   assign at_first = (cnt == '0);
   assign at_last  = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!active || at_last) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

   // R9
   idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> at_first);

endmodule

// File: rtl/flane_serializer.sv
module flane_serializer #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        if_code,
   input  logic [2:0]        phase,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              byte_done,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_valid
);
   import flane_pkg::*;

   generate
      if (BYTE_W < 8 || (BYTE_W % 4) != 0) begin : g_bad_width
         $error("flane_serializer: BYTE_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   lw_e        lw;
   logic       drive;
   logic       sample;
   logic       active;
   logic [3:0] lane_mask;
   logic       at_first;
   logic       at_last;

   flane_decode u_dec (
      .if_code   (if_code),
      .phase     (phase),
      .lw        (lw),
      .drive     (drive),
      .sample    (sample),
      .lane_mask (lane_mask)
   );

   assign active = drive | sample;

   flane_counter #(.BYTE_W(BYTE_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .lw       (lw),
      .at_first (at_first),
      .at_last  (at_last)
   );

   assign byte_done = active & at_last;

   // transmit path
   logic [BYTE_W-1:0] tx_sh;
   logic [BYTE_W-1:0] tx_word;
   logic [BYTE_W-1:0] tx_rest;
   logic [3:0]        tx_lanes;

   assign tx_word = at_first ? tx_byte : tx_sh;

   always_comb begin
      case (lw)
         LW4:     tx_rest = {tx_word[BYTE_W-5:0], 4'b0000};
         LW2:     tx_rest = {tx_word[BYTE_W-3:0], 2'b00};
         default: tx_rest = {tx_word[BYTE_W-2:0], 1'b0};
      endcase
   end

   generate
      for (genvar l = 0; l < 4; l++) begin : g_lane
         if (l == 0) begin : g_l0
            assign tx_lanes[l] = (lw == LW4) ? tx_word[BYTE_W-4] :
                                 (lw == LW2) ? tx_word[BYTE_W-2] : tx_word[BYTE_W-1];
         end else if (l == 1) begin : g_l1
            assign tx_lanes[l] = (lw == LW4) ? tx_word[BYTE_W-3] :
                                 (lw == LW2) ? tx_word[BYTE_W-1] : 1'b0;
         end else begin : g_lhi
            assign tx_lanes[l] = (lw == LW4) ? tx_word[BYTE_W-4+l] : 1'b0;
         end
      end
   endgenerate

   // receive path
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] rx_next;

   always_comb begin
      case (lw)
         LW4:     rx_next = {rx_sh[BYTE_W-5:0], io_in[3:0]};
         LW2:     rx_next = {rx_sh[BYTE_W-3:0], io_in[1:0]};
         default: rx_next = {rx_sh[BYTE_W-2:0], io_in[1]};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_out   <= '0;
         io_oe    <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
      end else begin
         if (drive) begin
            io_out <= tx_lanes;
            io_oe  <= lane_mask;
            tx_sh  <= tx_rest;
         end else begin
            io_out <= '0;
            io_oe  <= '0;
         end
         if (sample) rx_sh <= rx_next[BYTE_W-2:0];
         rx_valid <= sample & at_last;
         if (sample && at_last) rx_byte <= rx_next;
      end
   end

   // R4
   done_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

   // R2
   cmd_single_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CMD) |=> (io_oe == 4'b0001));

   // R7
   dummy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DUMMY) |=> (io_oe == 4'b0000 && io_out == 4'b0000));

   // R8
   rx_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase == PH_RDATA) |=> rx_valid);

   // R8
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |=> (io_oe == 4'b0000 && io_out == 4'b0000));

endmodule

// File: tb/tb_flane_serializer.sv
`timescale 1ns/1ps
module tb_flane_serializer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] if_code = '0;
   logic [2:0] phase = '0;
   logic [7:0] tx_byte = '0;
   logic       byte_done;
   logic [3:0] io_out;
   logic [3:0] io_oe;
   logic [3:0] io_in = '0;
   logic [7:0] rx_byte;
   logic       rx_valid;

   int checks = 0;
   int fails  = 0;

   // behavioural reference state
   int         m_cnt = 0;
   logic [7:0] m_word = '0;
   logic [7:0] m_acc = '0;
   logic [7:0] m_rx = '0;
   logic       m_rv = 1'b0;
   logic [3:0] m_out = '0;
   logic [3:0] m_oe = '0;

   always #2.5 clk = ~clk;

   flane_serializer dut (
      .clk(clk), .rst_n(rst_n), .if_code(if_code), .phase(phase),
      .tx_byte(tx_byte), .byte_done(byte_done), .io_out(io_out),
      .io_oe(io_oe), .io_in(io_in), .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   function automatic int lanes_of(input logic [2:0] code, input logic [2:0] ph);
      int c;
      c = (code > 3'd4) ? 0 : int'(code);
      if (ph == 3'd2) return (c == 2) ? 2 : (c == 4) ? 4 : 1;
      if (ph == 3'd4 || ph == 3'd5) begin
         if (c == 1 || c == 2) return 2;
         if (c == 3 || c == 4) return 4;
      end
      return 1;
   endfunction

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] code, input logic [2:0] ph, input logic [7:0] txb,
                       input logic [3:0] ioin, input string req);
      int n;
      int steps;
      bit drv;
      bit smp;
      bit done;
      logic [7:0] w;
      logic [3:0] g;
      @(negedge clk);
      if_code = code; phase = ph; tx_byte = txb; io_in = ioin;
      n = lanes_of(code, ph);
      steps = 8 / n;
      drv = (ph == 3'd1 || ph == 3'd2 || ph == 3'd4);
      smp = (ph == 3'd5);
      done = (drv || smp) && (m_cnt == steps - 1);
      #1;
      chk({req, " R4"}, "byte_done", {7'b0, byte_done}, {7'b0, done});
      if (drv) begin
         w = (m_cnt == 0) ? txb : m_word;
         m_out = '0;
         for (int j = 0; j < n; j++) m_out[j] = w[8 - n + j];
         m_oe = 4'((1 << n) - 1);
         m_word = w << n;
      end else begin
         m_out = '0;
         m_oe = '0;
      end
      m_rv = 1'b0;
      if (smp) begin
         g = '0;
         if (n == 1) g[0] = ioin[1];
         else for (int j = 0; j < n; j++) g[j] = ioin[j];
         m_acc = (m_acc << n) | {4'b0, g};
         if (done) begin
            m_rx = m_acc;
            m_rv = 1'b1;
         end
      end
      m_cnt = (drv || smp) ? (done ? 0 : m_cnt + 1) : 0;
      @(posedge clk);
      #1;
      chk({req, " R3"}, "io_out", {4'b0, io_out}, {4'b0, m_out});
      chk({req, drv ? " R6" : (ph == 3'd3) ? " R7" : (ph == 3'd5) ? " R8" : " R9"},
          "io_oe", {4'b0, io_oe}, {4'b0, m_oe});
      chk({req, " R8"}, "rx_valid", {7'b0, rx_valid}, {7'b0, m_rv});
      chk({req, " R8"}, "rx_byte", rx_byte, m_rx);
   endtask

   task automatic send_byte(input logic [2:0] code, input logic [2:0] ph, input logic [7:0] b,
                            input string req);
      int n;
      logic [7:0] rebuilt;
      n = lanes_of(code, ph);
      rebuilt = '0;
      for (int s = 0; s < 8 / n; s++) begin
         // later clocks carry a different byte, which must be ignored (R5)
         step(code, ph, (s == 0) ? b : ~b, 4'b0000, req);
         if (n == 1) rebuilt = {rebuilt[6:0], io_out[0]};
         else if (n == 2) rebuilt = {rebuilt[5:0], io_out[1:0]};
         else rebuilt = {rebuilt[3:0], io_out[3:0]};
      end
      chk({req, " R3 R5"}, "rebuilt tx byte", rebuilt, b);
   endtask

   task automatic recv_byte(input logic [2:0] code, input logic [7:0] fb, input string req);
      int n;
      logic [3:0] grp;
      logic [3:0] pins;
      n = lanes_of(code, 3'd5);
      for (int s = 0; s < 8 / n; s++) begin
         grp = 4'((fb >> (8 - n * (s + 1))) & ((1 << n) - 1));
         if (n == 1) pins = {2'b11, grp[0], ~grp[0]};
         else if (n == 2) pins = {~grp[1:0], grp[1:0]};
         else pins = grp;
         step(code, 3'd5, 8'h00, pins, req);
      end
      chk({req, " R8"}, "received byte", rx_byte, fb);
      chk({req, " R8"}, "rx_valid pulse", {7'b0, rx_valid}, 8'h01);
   endtask

   task automatic xfer(input logic [2:0] code, input bit rd, input int nb,
                       input logic [7:0] seed, input string req);
      send_byte(code, 3'd1, seed, req);
      for (int a = 0; a < 3; a++) send_byte(code, 3'd2, seed + 8'(a * 37 + 1), req);
      if (rd) begin
         for (int d = 0; d < 4; d++) step(code, 3'd3, 8'hA5, 4'hF, {req, " R7"});
         for (int k = 0; k < nb; k++) recv_byte(code, seed ^ 8'(k * 91 + 7), req);
      end else begin
         for (int k = 0; k < nb; k++) send_byte(code, 3'd4, seed ^ 8'(k * 53 + 3), req);
      end
      step(code, 3'd0, 8'h00, 4'h0, {req, " R9"});
      step(code, 3'd0, 8'h00, 4'h0, {req, " R9"});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "io_oe in reset", {4'b0, io_oe}, 8'h00);
      chk("R1", "io_out in reset", {4'b0, io_out}, 8'h00);
      chk("R1", "rx_valid in reset", {7'b0, rx_valid}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "rx_byte after reset", rx_byte, 8'h00);
      chk("R1", "byte_done after reset", {7'b0, byte_done}, 8'h00);

      for (int c = 0; c < 8; c++) begin
         xfer(3'(c), 1'b1, 3, 8'(8'h3B + c * 17), (c > 4) ? "R10 read" : "R2 read");
         xfer(3'(c), 1'b0, 2, 8'(8'hC2 + c * 29), (c > 4) ? "R10 write" : "R2 write");
      end

      // partial command byte abandoned by idle; next byte must start clean (R9)
      for (int s = 0; s < 3; s++) step(3'd4, 3'd1, 8'h81, 4'h0, "R9 abort");
      step(3'd4, 3'd0, 8'h00, 4'h0, "R9 abort idle");
      send_byte(3'd4, 3'd1, 8'h6C, "R9 restart");
      // back-to-back quad data bytes with no gap (R4)
      send_byte(3'd4, 3'd4, 8'hE1, "R4 quad burst");
      send_byte(3'd4, 3'd4, 8'h1E, "R4 quad burst");
      step(3'd0, 3'd7, 8'hFF, 4'hF, "R9 reserved phase");
      step(3'd0, 3'd0, 8'h00, 4'h0, "R9 idle");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule